// File: doc/BRIEF.md
# Dual Prescaled Interval Timer with Shared Output Pin

The block holds two independent interval timers. Each timer divides a slow timing tick, one pulse every eight system clocks, first through a 6-bit prescaler and then through an 8-bit down-counter. When both reach their terminal count in the same tick, the channel flags an end-of-count. Software loads start values through a small write port, starts and stops each channel with an enable bit, and can sample the live counter through a read select at any moment.

Start values go into holding registers and never disturb a running count. They are copied into the counters only when software issues a load strobe. A continuous channel also copies them on its own at every end-of-count. The prescaler always refills itself from its holding value. A channel in single-pass mode stops after one end-of-count. Each channel keeps a square-wave output that toggles on every end-of-count. One shared pin shows channel 0's wave, channel 1's wave, the tick-rate clock, or a plain data bit.

Top module: `dual_interval_timer`

## Requirements
- R1: In continuous mode the time between two consecutive end-of-count pulses is exactly 8·p·v system clocks. p is prescale register bits 7:2, where 0 means 64. v is count register bits 7:0, where 0 means 256. The prescaler refills itself from its holding value on every wrap. Register addresses: 0 control, 1 channel-0 count, 2 channel-0 prescale, 3 channel-1 count, 4 channel-1 prescale.
- R2: With prescale bit 0 cleared (single-pass), the channel signals one end-of-count. Its counter then reads 0, its enable bit clears, and no further end-of-count follows until it is loaded and enabled again.
- R3: Clearing the channel enable bit freezes the counter, and setting it again resumes the count from the frozen value. The enable bits are control bit 1 for channel 0 and control bit 3 for channel 1.
- R4: `rd_data` shows the live counter of the channel chosen by `rd_sel`, and switching `rd_sel` has no effect on counting.
- R5: Writes to a count register leave the running count alone. In continuous mode (prescale bit 0 set), the counter takes the held count at the same edge as the end-of-count.
- R6: A control write with a load bit set copies both holding values into that channel and drives its wave output to 1 at that edge. The load bits are bit 0 for channel 0 and bit 2 for channel 1. A control write with the load bit at 0 changes neither that channel's count nor its output.
- R7: Each channel's wave output inverts at every end-of-count of that channel.
- R8: Control bits 7:6 select the pin source: 00 gives `port_data`, 01 gives the channel-0 wave, 10 gives the channel-1 wave, and 11 gives the tick clock, which is high 4 of every 8 system clocks.
- R9: `pin_oe` is the inverse of `pin_input_mode`.
- R10: After reset, both counters read 0, both channels are disabled, the pin source is 00 and no end-of-count is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW (8) | Write data |
| rd_sel | input | 1 | Channel whose live count is shown |
| rd_data | output | CNT_W (8) | Live counter of selected channel |
| port_data | input | 1 | Data bit driven on the pin when source is 00 |
| pin_input_mode | input | 1 | 1 makes the pin an input |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| eoc_pulse | output | 2 | One-cycle end-of-count flag per channel, high in the cycle before the edge that acts on it |

## Verification
A register write takes effect at the clock edge that samples it. The bench drives each write between two falling edges and reads the effects, such as the wave output forced high or the frozen count, at the very next falling edge. An end-of-count flag is high for the one cycle before the edge that reloads or stops the counter. Periods are therefore measured as cycle stamps between falling edges where the flag is seen, which makes them exact, and the toggled pin and reloaded count are sampled one falling edge later. Delays that start from a write depend on where the tick divider stands, so they are checked against a window one tick wide rather than a single cycle.

// File: rtl/dit_pkg.sv
package dit_pkg;
   localparam int NUM_CH  = 2;
   localparam int SEL_W   = 1;
   localparam int ADDR_W  = 3;
   localparam int SEL_LSB = 6;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;

   typedef enum logic [1:0] {
      PIN_DATA = 2'b00,
      PIN_CH0  = 2'b01,
      PIN_CH1  = 2'b10,
      PIN_CLK  = 2'b11
   } pin_src_e;

   function automatic logic [ADDR_W-1:0] addr_count(input int ch);
      return ADDR_W'(1 + 2 * ch);
   endfunction

   function automatic logic [ADDR_W-1:0] addr_prescale(input int ch);
      return ADDR_W'(2 + 2 * ch);
   endfunction
endpackage

// File: rtl/dit_tick_gen.sv
module dit_tick_gen #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick,
   output logic clk_sq
);
   localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);
   localparam logic [W-1:0] HALF = W'(DIV / 2);

   if (DIV < 2) begin : g_bad_div
      $error("tick divider must be at least 2");
   end

   logic [W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                    div_q <= div_q + 1'b1;
   end

   assign tick   = (div_q == LAST);
   assign clk_sq = (div_q >= HALF);

   // R1: the timing tick never fires on two adjacent clocks
   assert_tick_sparse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/dit_regs.sv
module dit_regs
   import dit_pkg::*;
#(
   parameter int DW    = 8,
   parameter int PRE_W = 6,
   parameter int CNT_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DW-1:0]                 wr_data,
   input  logic [NUM_CH-1:0]             stop_req,
   output logic [NUM_CH-1:0][CNT_W-1:0]  cnt_hold,
   output logic [NUM_CH-1:0][PRE_W-1:0]  pre_hold,
   output logic [NUM_CH-1:0]             cont_mode,
   output logic [NUM_CH-1:0]             run_en,
   output logic [NUM_CH-1:0]             load_stb,
   output logic                          ctrl_wr,
   output pin_src_e                      pin_src
);
   if (DW < 8)            begin : g_bad_dw  $error("data width below 8"); end
   if (CNT_W > DW)        begin : g_bad_cnt $error("count wider than data"); end
   if (PRE_W + 2 > DW)    begin : g_bad_pre $error("prescale field does not fit"); end
   if (2 * NUM_CH > SEL_LSB) begin : g_bad_ch $error("control bits overlap"); end

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_hold  <= '0;
         pre_hold  <= '0;
         cont_mode <= '0;
         run_en    <= '0;
         pin_src   <= PIN_DATA;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en && wr_addr == addr_count(c))
               cnt_hold[c] <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == addr_prescale(c)) begin
               pre_hold[c]  <= wr_data[PRE_W+1:2];
               cont_mode[c] <= wr_data[0];
            end
            if (ctrl_wr)          run_en[c] <= wr_data[2*c+1];
            else if (stop_req[c]) run_en[c] <= 1'b0;
         end
         if (ctrl_wr) pin_src <= pin_src_e'(wr_data[SEL_LSB+1:SEL_LSB]);
      end
   end

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) load_stb[c] = ctrl_wr && wr_data[2*c];
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // R2: a single-pass end-of-count drops the enable bit
      assert_single_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
         stop_req[g] && !ctrl_wr |=> !run_en[g]);
   end
endmodule

// File: rtl/dit_channel.sv
module dit_channel #(
   parameter int PRE_W = 6,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic             cont_mode,
   input  logic             load,
   input  logic [PRE_W-1:0] pre_hold,
   input  logic [CNT_W-1:0] cnt_hold,
   output logic [CNT_W-1:0] live_cnt,
   output logic             eoc,
   output logic             stop_req,
   output logic             wave
);
   localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wave_q;
   logic             step;
   logic             pre_wrap;

   assign step     = tick && run_en;
   assign pre_wrap = step && (pre_q == PRE_ONE);
   assign eoc      = pre_wrap && (cnt_q == CNT_ONE);
   assign stop_req = eoc && !cont_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         cnt_q  <= '0;
         wave_q <= 1'b1;
      end else if (load) begin
         pre_q  <= pre_hold;
         cnt_q  <= cnt_hold;
         wave_q <= 1'b1;
      end else if (step) begin
         pre_q <= (pre_q == PRE_ONE) ? pre_hold : pre_q - 1'b1;
         if (pre_q == PRE_ONE) begin
            if (cnt_q == CNT_ONE) begin
               cnt_q  <= cont_mode ? cnt_hold : '0;
               wave_q <= !wave_q;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign live_cnt = cnt_q;
   assign wave     = wave_q;

   // R3: a disabled channel holds both counters
   assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en && !load |=> $stable(cnt_q) && $stable(pre_q));
   // R6: a load drives the wave high and takes the held count
   assert_load_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> wave_q && (cnt_q == $past(cnt_hold)));
   // R5: continuous end-of-count reloads from the holding register
   assert_cont_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eoc && cont_mode && !load |=> cnt_q == $past(cnt_hold));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int DW       = 8,
   parameter int PRE_W    = 6,
   parameter int CNT_W    = 8,
   parameter int TICK_DIV = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              port_data,
   input  logic              pin_input_mode,
   output logic              pin_out,
   output logic              pin_oe,
   output logic [NUM_CH-1:0] eoc_pulse
);
   logic                         tick;
   logic                         clk_sq;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt_hold;
   logic [NUM_CH-1:0][PRE_W-1:0] pre_hold;
   logic [NUM_CH-1:0]            cont_mode;
   logic [NUM_CH-1:0]            run_en;
   logic [NUM_CH-1:0]            load_stb;
   logic [NUM_CH-1:0]            stop_req;
   logic [NUM_CH-1:0]            wave;
   logic [NUM_CH-1:0][CNT_W-1:0] live_cnt;
   logic                         ctrl_wr;
   pin_src_e                     pin_src;

   dit_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .clk_sq (clk_sq)
   );

   dit_regs #(.DW(DW), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .stop_req  (stop_req),
      .cnt_hold  (cnt_hold),
      .pre_hold  (pre_hold),
      .cont_mode (cont_mode),
      .run_en    (run_en),
      .load_stb  (load_stb),
      .ctrl_wr   (ctrl_wr),
      .pin_src   (pin_src)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dit_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .run_en    (run_en[c]),
         .cont_mode (cont_mode[c]),
         .load      (load_stb[c]),
         .pre_hold  (pre_hold[c]),
         .cnt_hold  (cnt_hold[c]),
         .live_cnt  (live_cnt[c]),
         .eoc       (eoc_pulse[c]),
         .stop_req  (stop_req[c]),
         .wave      (wave[c])
      );
   end

   always_comb begin
      case (pin_src)
         PIN_DATA: pin_out = port_data;
         PIN_CH0:  pin_out = wave[0];
         PIN_CH1:  pin_out = wave[1];
         PIN_CLK:  pin_out = clk_sq;
         default:  pin_out = port_data;
      endcase
   end

   assign pin_oe  = !pin_input_mode;
   assign rd_data = live_cnt[rd_sel];

   // R7: the pin follows channel 0's wave inversion at an end-of-count
   assert_pin_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_pulse[0] && !load_stb[0] && !ctrl_wr && pin_src == PIN_CH0
      |=> pin_out != $past(pin_out));
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [0:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       port_data = 1'b0;
   logic       pin_input_mode = 1'b0;
   logic       pin_out;
   logic       pin_oe;
   logic [1:0] eoc_pulse;

   int n_chk = 0;
   int n_fail = 0;
   int cyc_now = 0;

   // {prescale[5:0], count[7:0], period in clocks[17:0]}
   localparam logic [31:0] VEC [5] = '{
      {6'd1, 8'd1, 18'd8},
      {6'd3, 8'd5, 18'd120},
      {6'd0, 8'd2, 18'd1024},
      {6'd2, 8'd0, 18'd4096},
      {6'd7, 8'd9, 18'd504}
   };

   dual_interval_timer u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_addr        (wr_addr),
      .wr_data        (wr_data),
      .rd_sel         (rd_sel),
      .rd_data        (rd_data),
      .port_data      (port_data),
      .pin_input_mode (pin_input_mode),
      .pin_out        (pin_out),
      .pin_oe         (pin_oe),
      .eoc_pulse      (eoc_pulse)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc_now <= cyc_now + 1;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_eoc(input int ch, output int stamp);
      do begin
         @(negedge clk);
         rd_sel = ~rd_sel;
      end while (!eoc_pulse[ch]);
      stamp = cyc_now;
   endtask

   task automatic read_cnt(input int ch, output int v);
      rd_sel = 1'(ch);
      #1;
      v = int'(rd_data);
   endtask

   initial begin
      wait (cyc_now > 190000);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      int e1, e2, s, v1, v2, hi, p1, p2, npulse;
      // R10: reset state
      port_data = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_cnt(0, v1); chk("R10 count0", v1, 0);
      read_cnt(1, v1); chk("R10 count1", v1, 0);
      chk("R10 pin source data", int'(pin_out), 1);
      port_data = 1'b0; #1;
      chk("R10 pin source data low", int'(pin_out), 0);
      chk("R10 no eoc", int'(eoc_pulse), 0);
      repeat (20) @(negedge clk);
      read_cnt(0, v1); chk("R10 disabled stays", v1, 0);

      // R1 R4 R5 R6 R7: vector table on channel 0, continuous mode
      for (int i = 0; i < 5; i++) begin
         logic [5:0] p;
         logic [7:0] v;
         int exp;
         p = VEC[i][31:26];
         v = VEC[i][25:18];
         exp = int'(VEC[i][17:0]);
         wr(3'd2, {p, 2'b01});
         wr(3'd1, v);
         wr(3'd0, 8'b0100_0011);
         chk("R6 load drives wave high", int'(pin_out), 1);
         wait_eoc(0, e1);
         wait_eoc(0, e2);
         chk("R1 period", e2 - e1, exp);
         p1 = int'(pin_out);
         @(negedge clk);
         p2 = int'(pin_out);
         chk("R7 wave toggles", int'(p1 != p2), 1);
         read_cnt(0, v1);
         chk("R5 reload at eoc", v1, int'(v));
      end

      // R5: held count used only at next reload
      wr(3'd2, 8'b0000_0101);
      wr(3'd1, 8'd4);
      wr(3'd0, 8'b0100_0011);
      wait_eoc(0, e1);
      wr(3'd1, 8'd6);
      wait_eoc(0, e2);
      chk("R5 old count kept", e2 - e1, 32);
      e1 = e2;
      wait_eoc(0, e2);
      chk("R5 new count after reload", e2 - e1, 48);

      // R6: control write without load bit leaves count and wave alone
      e1 = e2;
      @(negedge clk);
      p1 = int'(pin_out);
      wr(3'd0, 8'b0100_0010);
      chk("R6 no-load keeps wave", int'(pin_out), p1);
      wait_eoc(0, e2);
      chk("R6 no-load keeps count", e2 - e1, 48);

      // R3: freeze and resume
      wr(3'd0, 8'b0100_0000);
      read_cnt(0, v1);
      chk("R3 frozen value", v1, 6);
      repeat (60) @(negedge clk);
      read_cnt(0, v2);
      chk("R3 value held", v2, v1);
      wr(3'd0, 8'b0100_0010);
      s = cyc_now;
      wait_eoc(0, e1);
      chk("R3 resume from held", int'((e1 - s) >= 40 && (e1 - s) <= 47), 1);

      // R2: single-pass on channel 1, pin on channel 1
      wr(3'd4, 8'b0000_1000);
      wr(3'd3, 8'd3);
      wr(3'd0, 8'b1000_1100);
      s = cyc_now;
      chk("R6 load ch1 wave high", int'(pin_out), 1);
      wait_eoc(1, e1);
      chk("R2 single-pass delay", int'((e1 - s) >= 40 && (e1 - s) <= 47), 1);
      @(negedge clk);
      read_cnt(1, v1);
      chk("R2 counter at zero", v1, 0);
      chk("R8 pin shows ch1 wave", int'(pin_out), 0);
      npulse = 0;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if (eoc_pulse[1]) npulse++;
      end
      chk("R2 no further eoc", npulse, 0);
      read_cnt(1, v1);
      chk("R2 stays stopped", v1, 0);

      // R8: tick clock and data sources
      wr(3'd0, 8'b1100_0000);
      hi = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         hi += int'(pin_out);
      end
      chk("R8 clock source duty", hi, 4);
      wr(3'd0, 8'b0000_0000);
      port_data = 1'b1; #1;
      chk("R8 data source high", int'(pin_out), 1);
      port_data = 1'b0; #1;
      chk("R8 data source low", int'(pin_out), 0);

      // R9: output enable
      pin_input_mode = 1'b1; #1;
      chk("R9 input mode", int'(pin_oe), 0);
      pin_input_mode = 1'b0; #1;
      chk("R9 output mode", int'(pin_oe), 1);

      summary();
   end
endmodule